// File: doc/BRIEF.md
# Segmented Address Translator

This block maps an 8-bit virtual address onto an 8-bit physical address through a four-entry segment table. The two most significant address bits pick a table entry. The remaining six bits form an offset. Each entry carries a base address and a limit. A request whose offset lies below the entry's limit gives back the base plus the offset. A request whose offset reaches or passes the limit is flagged as a fault, and no address is produced for it.

Software or a setup sequencer loads the table through a single write port that carries an enable, an entry index, a base and a limit. Requests arrive one per cycle with a valid strobe. Each accepted request produces a registered response on the next cycle. The response has a success flag, a fault flag and the physical address. After reset every entry has base 0 and limit 0, so all accesses fault until the table has been loaded.

Top module: `seg_xlat_unit`

## Requirements
- R1: While rst_ni is low, rsp_valid_o and rsp_fault_o are 0 and rsp_paddr_o is 0x00.
- R2: The segment index is vaddr bits [7:6] and the offset is vaddr bits [5:0]. For every one of the 256 virtual addresses, the response matches the entry selected by bits [7:6].
- R3: When the offset is strictly less than the entry's limit, the response has rsp_valid_o=1, rsp_fault_o=0 and rsp_paddr_o=(base+offset) mod 256. A sum above 0xFF wraps.
- R4: When the offset is greater than or equal to the entry's limit, the response has rsp_fault_o=1, rsp_valid_o=0 and rsp_paddr_o=0x00.
- R5: The response appears on the outputs in the cycle after the cycle in which req_valid_i was sampled high. A cycle with req_valid_i low produces rsp_valid_o=0, rsp_fault_o=0 and rsp_paddr_o=0x00 in the following cycle.
- R6: When tbl_we_i is high at a clock edge, entry tbl_idx_i takes tbl_base_i and tbl_limit_i. Requests sampled at later edges use the new values.
- R7: When a request and a table write to the same entry are sampled at the same edge, the translation uses the entry's contents from before the write.
- R8: After reset every entry has base 0 and limit 0, so every request faults until its entry has been written.
- R9: The limit is 7 bits wide. A limit of 0x40 lets every offset through, including 0x3F.
- R10: A write to one entry leaves the other three entries unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request strobe |
| req_vaddr_i | input | 8 | Virtual address to translate |
| tbl_we_i | input | 1 | Table write enable |
| tbl_idx_i | input | 2 | Table entry to write |
| tbl_base_i | input | 8 | Base address to store |
| tbl_limit_i | input | 7 | Limit to store (0 to 64) |
| rsp_valid_o | output | 1 | Successful translation response |
| rsp_fault_o | output | 1 | Limit-violation response |
| rsp_paddr_o | output | 8 | Physical address, 0 unless rsp_valid_o |

## Verification
A table write and a translation can land on the same entry at the same clock edge. The bench provokes this by rewriting segment 1 to a wider limit while it requests an offset that only the new limit would admit. The response must still be a fault, because the old entry is the one that counts. The next request to that offset must then succeed with the new base. A second case pairs a request to one entry with a write to a different entry, to confirm that the write does not disturb the translation.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned SEG_W  = 2;
  localparam int unsigned OFF_W  = ADDR_W - SEG_W;
  localparam int unsigned N_SEG  = 1 << SEG_W;
  localparam int unsigned LIM_W  = OFF_W + 1;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [LIM_W-1:0]  limit;
  } seg_entry_t;
endpackage

// File: rtl/seg_table.sv
module seg_table
  import seg_xlat_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SEG_W-1:0] wr_idx_i,
  input  seg_entry_t       wr_entry_i,
  input  logic [SEG_W-1:0] rd_idx_i,
  output seg_entry_t       rd_entry_o
);
  seg_entry_t entry_q [N_SEG];

  for (genvar g = 0; g < N_SEG; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    entry_q[g] <= '0;
      else if (we_i && (wr_idx_i == SEG_W'(g)))      entry_q[g] <= wr_entry_i;
    end
  end

  // read returns pre-write contents on a same-edge write
  assign rd_entry_o = entry_q[rd_idx_i];
endmodule

// File: rtl/seg_xlat_core.sv
module seg_xlat_core
  import seg_xlat_pkg::*;
(
  input  logic [OFF_W-1:0]  offset_i,
  input  seg_entry_t        entry_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] paddr_o
);
  assign hit_o   = {1'b0, offset_i} < entry_i.limit;
  assign paddr_o = entry_i.base + ADDR_W'(offset_i);
endmodule

// File: rtl/seg_xlat_unit.sv
module seg_xlat_unit
  import seg_xlat_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_vaddr_i,
  input  logic              tbl_we_i,
  input  logic [SEG_W-1:0]  tbl_idx_i,
  input  logic [ADDR_W-1:0] tbl_base_i,
  input  logic [LIM_W-1:0]  tbl_limit_i,
  output logic              rsp_valid_o,
  output logic              rsp_fault_o,
  output logic [ADDR_W-1:0] rsp_paddr_o
);
  logic [SEG_W-1:0]  seg_idx;
  logic [OFF_W-1:0]  offset;
  seg_entry_t        wr_entry, rd_entry;
  logic              hit;
  logic [ADDR_W-1:0] paddr;

  assign seg_idx        = req_vaddr_i[ADDR_W-1 -: SEG_W];
  assign offset         = req_vaddr_i[OFF_W-1:0];
  assign wr_entry.base  = tbl_base_i;
  assign wr_entry.limit = tbl_limit_i;

  seg_table u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (tbl_we_i),
    .wr_idx_i   (tbl_idx_i),
    .wr_entry_i (wr_entry),
    .rd_idx_i   (seg_idx),
    .rd_entry_o (rd_entry)
  );

  seg_xlat_core u_core (
    .offset_i (offset),
    .entry_i  (rd_entry),
    .hit_o    (hit),
    .paddr_o  (paddr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_fault_o <= 1'b0;
      rsp_paddr_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i && hit;
      rsp_fault_o <= req_valid_i && !hit;
      rsp_paddr_o <= (req_valid_i && hit) ? paddr : '0;
    end
  end
endmodule

// File: rtl/seg_xlat_chk.sv
module seg_xlat_chk
  import seg_xlat_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [ADDR_W-1:0] req_vaddr_i,
  input logic              tbl_we_i,
  input logic [SEG_W-1:0]  tbl_idx_i,
  input logic              rsp_valid_o,
  input logic              rsp_fault_o,
  input logic [ADDR_W-1:0] rsp_paddr_o
);
  logic [N_SEG-1:0] loaded_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       loaded_q <= '0;
    else if (tbl_we_i) loaded_q[tbl_idx_i] <= 1'b1;
  end

  p_excl_flags_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rsp_valid_o && rsp_fault_o));

  p_fault_addr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o |-> (rsp_paddr_o == '0));

  p_resp_next_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (rsp_valid_o || rsp_fault_o));

  p_idle_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!rsp_valid_o && !rsp_fault_o && rsp_paddr_o == '0));

  p_unloaded_fault_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !loaded_q[req_vaddr_i[ADDR_W-1 -: SEG_W]]) |=> rsp_fault_o);

  always_comb begin
    if (!rst_ni) begin
      a_reset_quiet_r1: assert (!rsp_valid_o && !rsp_fault_o);
    end
  end
endmodule

bind seg_xlat_unit seg_xlat_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_vaddr_i (req_vaddr_i),
  .tbl_we_i    (tbl_we_i),
  .tbl_idx_i   (tbl_idx_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_fault_o (rsp_fault_o),
  .rsp_paddr_o (rsp_paddr_o)
);

// File: tb/seg_xlat_unit_test.sv
`timescale 1ns/1ps
module seg_xlat_unit_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_valid_i = 1'b0;
  logic [7:0] req_vaddr_i = '0;
  logic       tbl_we_i = 1'b0;
  logic [1:0] tbl_idx_i = '0;
  logic [7:0] tbl_base_i = '0;
  logic [6:0] tbl_limit_i = '0;
  logic       rsp_valid_o, rsp_fault_o;
  logic [7:0] rsp_paddr_o;

  int n_vec = 0;
  int n_bad = 0;
  int m_base [4];
  int m_lim  [4];

  always #4 clk_i = ~clk_i;  // 125 MHz

  seg_xlat_unit uut (.*);

  task automatic check(string tag, int v, int f, int pa);
    n_vec++;
    if (rsp_valid_o !== v[0] || rsp_fault_o !== f[0] || rsp_paddr_o !== pa[7:0]) begin
      n_bad++;
      $display("FAIL %s: got valid=%0b fault=%0b paddr=%02h, expected valid=%0b fault=%0b paddr=%02h",
               tag, rsp_valid_o, rsp_fault_o, rsp_paddr_o, v[0], f[0], pa[7:0]);
    end
  endtask

  // one cycle: drive at negedge, model updates after computing expectation, compare at next negedge
  task automatic step(string tag, bit rv, int va, bit we, int idx, int b, int l);
    int seg, off, ev, ef, ep;
    req_valid_i = rv; req_vaddr_i = va[7:0];
    tbl_we_i = we; tbl_idx_i = idx[1:0]; tbl_base_i = b[7:0]; tbl_limit_i = l[6:0];
    seg = va / 64; off = va % 64;
    ev = 0; ef = 0; ep = 0;
    if (rv) begin
      if (off < m_lim[seg]) begin ev = 1; ep = (m_base[seg] + off) % 256; end
      else ef = 1;
    end
    if (we) begin m_base[idx] = b; m_lim[idx] = l; end
    @(negedge clk_i);
    check(tag, ev, ef, ep);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin m_base[i] = 0; m_lim[i] = 0; end
    repeat (3) @(negedge clk_i);
    check("R1", 0, 0, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R8: empty table faults
    step("R8", 1, 8'h05, 0, 0, 0, 0);
    step("R8", 1, 8'hC0, 0, 0, 0, 0);
    // R6: load table, R5: idle cycles quiet
    step("R5", 0, 0, 1, 3, 8'hB0, 8'h10);
    step("R6", 0, 0, 1, 2, 8'h70, 8'h18);
    step("R6", 0, 0, 1, 1, 8'h50, 8'h20);
    step("R6", 0, 0, 1, 0, 8'h10, 8'h20);
    // R3: in-range translations
    step("R3", 1, 8'h05, 0, 0, 0, 0);
    step("R3", 1, 8'h45, 0, 0, 0, 0);
    step("R3", 1, 8'h97, 0, 0, 0, 0);
    step("R3", 1, 8'hCF, 0, 0, 0, 0);
    // R4: at and past the limit
    step("R4", 1, 8'hD0, 0, 0, 0, 0);
    step("R4", 1, 8'h98, 0, 0, 0, 0);
    step("R4", 1, 8'h3F, 0, 0, 0, 0);
    step("R5", 0, 0, 0, 0, 0, 0);
    // R7: same-edge write to the requested entry uses the old limit
    step("R7", 1, 8'h70, 1, 1, 8'h00, 8'h40);
    step("R7", 1, 8'h70, 0, 0, 0, 0);
    // R9: full-size segment
    step("R9", 1, 8'h7F, 0, 0, 0, 0);
    // R10: other entries intact; write elsewhere during a request
    step("R10", 1, 8'h05, 1, 3, 8'hF0, 8'h40);
    step("R10", 1, 8'h97, 0, 0, 0, 0);
    // R3: wraparound
    step("R3", 1, 8'hE0, 0, 0, 0, 0);
    // R2: full sweep, back-to-back
    for (int a = 0; a < 256; a++) step("R2", 1, a, 0, 0, 0, 0);
    step("R5", 0, 0, 0, 0, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule